// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation lookaside buffer for 32-bit virtual addresses. Every entry describes two neighbouring pages, an even half and an odd half, that share one virtual tag, one page-size mask, one 8-bit address-space identifier and one global flag. Each half has its own physical frame number, valid bit and dirty bit. Software fills entries through an indexed write port. A lookup port takes a virtual address, a read/write flag and the current address-space identifier. It returns a result code, the physical address and a writable flag.

A lookup can fail in three ways. No entry may hit. The hit may land on a half whose valid bit is clear. A write may land on a half whose dirty bit is clear. Each failure has its own result code. When a lookup request fails, two capture registers record the faulting address for the handler: a context register and an entry-high register. Software can also load each capture register directly. The entry count is a parameter. A second parameter registers the lookup result, which then appears one clock later.

Top module: `pair_tlb`

## Requirements
- R1: An entry hits when its global flag is set or its stored identifier equals `lk_asid`, and `lk_addr` with the effective-mask bits cleared equals the stored tag with the same bits cleared. The stored tag `wr_vpn` holds address bits 31:13.
- R2: The effective mask is `{wr_mask, 13'h1FFF}`, where `wr_mask` holds mask bits 31:13, so the smallest pair is two 4 KB pages. On a hit, `res_paddr` is `{pfn, 12'b0}` OR (`lk_addr` AND the effective mask shifted right by one).
- R3: The highest set bit of the effective mask, taken from `lk_addr`, selects the half. A value of 1 selects the odd half (`wr_pfn1`, `wr_valid[1]`, `wr_dirty[1]`) and 0 selects the even half (`wr_pfn0`, bit 0 of the flags).
- R4: If the selected half is not valid, `res_code` is 2 (invalid) for both reads and writes.
- R5: A read of a valid half returns code 0 (hit). A write returns code 0 only when the half's dirty bit is set, and code 3 (modify) otherwise. On a hit, `res_writable` equals the selected dirty bit.
- R6: If no entry hits, `res_code` is 1 (no-match). For any code other than 0, `res_paddr` and `res_writable` are 0.
- R7: If several entries hit, the entry with the lowest index decides the result.
- R8: On a clock edge with `lk_req` high and a nonzero code, context bits 22:4 take `lk_addr[31:13]` and all other context bits are kept.
- R9: On the same fault edge, entry-high bits 31:13 take `lk_addr[31:13]`, bits 12:8 become 0, and bits 7:0 are kept. A request with code 0 leaves both capture registers unchanged.
- R10: After synchronous reset, every entry has tag 0, mask 0, identifier 0, global 0 and both halves invalid. Both capture registers are 0.
- R11: With `REGISTERED=1`, the result outputs show the lookup presented before the previous clock edge and hold that value until the next edge. With `REGISTERED=0`, they follow the lookup inputs combinationally.
- R12: `cap_ctx_we` or `cap_ehi_we` loads `cap_wdata` into the context or entry-high register. A software write takes priority over a fault capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | $clog2(ENTRIES) | Entry index to write |
| wr_vpn | input | 19 | Pair tag, virtual address bits 31:13 |
| wr_mask | input | 19 | Page-size mask bits 31:13 |
| wr_asid | input | 8 | Address-space identifier |
| wr_global | input | 1 | Match any identifier |
| wr_pfn0 | input | 20 | Even-half physical frame (address bits 31:12) |
| wr_pfn1 | input | 20 | Odd-half physical frame |
| wr_valid | input | 2 | Valid bits, bit 1 for the odd half |
| wr_dirty | input | 2 | Dirty (write-permitted) bits, bit 1 for the odd half |
| lk_req | input | 1 | Lookup request; a failing request loads the capture registers |
| lk_addr | input | 32 | Virtual address |
| lk_write | input | 1 | 1 for a store, 0 for a load |
| lk_asid | input | 8 | Current address-space identifier |
| cap_ctx_we | input | 1 | Software write of the context register |
| cap_ehi_we | input | 1 | Software write of the entry-high register |
| cap_wdata | input | 32 | Data for the capture-register writes |
| res_code | output | 2 | 0 hit, 1 no-match, 2 invalid, 3 modify |
| res_paddr | output | 32 | Physical address |
| res_writable | output | 1 | Selected half permits writes |
| cap_ctx | output | 32 | Context capture register |
| cap_ehi | output | 32 | Entry-high capture register |

## Verification
The assertions check four properties on every cycle. The winning entry is the lowest-indexed hit, a modify code only comes from a write, and a write hit is always writable. A failing request also loads the context and entry-high fields exactly while keeping the protected bits. The bench's scenarios cover the rest. They check the half selection at different page sizes, the identifier and global matching, the exact physical address arithmetic, the state left by reset, and the one-cycle hold of the registered variant. Each of these is compared against an arithmetic model of the entry table.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    localparam int VA_W    = 32;
    localparam int PAGE_SH = 12;
    localparam int PAIR_SH = 13;
    localparam int VPN_W   = VA_W - PAIR_SH;
    localparam int PFN_W   = VA_W - PAGE_SH;
    localparam int ASID_W  = 8;

    typedef struct packed {
        logic [VPN_W-1:0]            vpn;
        logic [VPN_W-1:0]            mask;
        logic [ASID_W-1:0]           asid;
        logic                        glob;
        logic [1:0][PFN_W-1:0]       pfn;
        logic [1:0]                  valid;
        logic [1:0]                  dirty;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_NOMATCH = 2'd1,
        RES_INVALID = 2'd2,
        RES_MODIFY  = 2'd3
    } res_code_t;

    function automatic logic [VA_W-1:0] eff_mask(input logic [VPN_W-1:0] m);
        return {m, {PAIR_SH{1'b1}}};
    endfunction

    function automatic logic pair_hit(input tlb_entry_t e,
                                      input logic [VA_W-1:0] va,
                                      input logic [ASID_W-1:0] asid);
        logic [VA_W-1:0] em;
        em = eff_mask(e.mask);
        return (e.glob || (e.asid == asid)) &&
               ((va & ~em) == ({e.vpn, {PAIR_SH{1'b0}}} & ~em));
    endfunction
endpackage

// File: rtl/ptlb_entry_bank.sv
module ptlb_entry_bank
    import ptlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic [VA_W-1:0]   lk_addr,
    input  logic [ASID_W-1:0] lk_asid,
    output tlb_entry_t        ent_q [ENTRIES],
    output logic [ENTRIES-1:0] hit_vec
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (wr_en && (int'(wr_idx) == i)) begin
                ent_q[i] <= wr_entry;
            end
        end
        assign hit_vec[i] = pair_hit(ent_q[i], lk_addr, lk_asid);
    end
endmodule

// File: rtl/ptlb_pick.sv
module ptlb_pick #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     hit_vec,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_any
);
    always_comb begin
        win_idx = '0;
        win_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_idx = IDX_W'(i);
                win_any = 1'b1;
            end
        end
    end

    // R7: the winner hits and no lower-indexed entry hits
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (rst)
        win_any |-> (hit_vec[win_idx] &&
                     ((hit_vec & ((N'(1) << win_idx) - N'(1))) == '0)));
endmodule

// File: rtl/ptlb_capture.sv
module ptlb_capture
    import ptlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fault_ld,
    input  logic [VA_W-1:0] va,
    input  logic            sw_ctx_we,
    input  logic            sw_ehi_we,
    input  logic [VA_W-1:0] sw_wdata,
    output logic [VA_W-1:0] ctx_q,
    output logic [VA_W-1:0] ehi_q
);
    localparam int CTX_LO = 4;
    localparam int CTX_HI = CTX_LO + VPN_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            ehi_q <= '0;
        end else begin
            if (sw_ctx_we) begin
                ctx_q <= sw_wdata;
            end else if (fault_ld) begin
                ctx_q[CTX_HI:CTX_LO] <= va[VA_W-1:PAIR_SH];
            end
            if (sw_ehi_we) begin
                ehi_q <= sw_wdata;
            end else if (fault_ld) begin
                ehi_q <= {va[VA_W-1:PAIR_SH], {(PAIR_SH-ASID_W){1'b0}}, ehi_q[ASID_W-1:0]};
            end
        end
    end

    // R8: context field loaded, surrounding bits kept
    p_ctx_load_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_ld && !sw_ctx_we) |=> (ctx_q[CTX_HI:CTX_LO] == $past(va[VA_W-1:PAIR_SH])) &&
                                     (ctx_q[CTX_LO-1:0] == $past(ctx_q[CTX_LO-1:0])) &&
                                     (ctx_q[VA_W-1:CTX_HI+1] == $past(ctx_q[VA_W-1:CTX_HI+1])));
    // R9: entry-high takes the pair tag and keeps its identifier byte
    p_ehi_load_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_ld && !sw_ehi_we) |=> (ehi_q[VA_W-1:PAIR_SH] == $past(va[VA_W-1:PAIR_SH])) &&
                                     (ehi_q[ASID_W-1:0] == $past(ehi_q[ASID_W-1:0])));
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
    import ptlb_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter bit REGISTERED = 1'b0,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [18:0]       wr_vpn,
    input  logic [18:0]       wr_mask,
    input  logic [7:0]        wr_asid,
    input  logic              wr_global,
    input  logic [19:0]       wr_pfn0,
    input  logic [19:0]       wr_pfn1,
    input  logic [1:0]        wr_valid,
    input  logic [1:0]        wr_dirty,
    input  logic              lk_req,
    input  logic [31:0]       lk_addr,
    input  logic              lk_write,
    input  logic [7:0]        lk_asid,
    input  logic              cap_ctx_we,
    input  logic              cap_ehi_we,
    input  logic [31:0]       cap_wdata,
    output logic [1:0]        res_code,
    output logic [31:0]       res_paddr,
    output logic              res_writable,
    output logic [31:0]       cap_ctx,
    output logic [31:0]       cap_ehi
);
    tlb_entry_t         wr_entry;
    tlb_entry_t         ent_q [ENTRIES];
    tlb_entry_t         win;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    logic [VA_W-1:0]    em, pmask;
    logic               odd;
    res_code_t          c_code;
    logic [VA_W-1:0]    c_paddr;
    logic               c_wr;

    always_comb begin
        wr_entry.vpn    = wr_vpn;
        wr_entry.mask   = wr_mask;
        wr_entry.asid   = wr_asid;
        wr_entry.glob   = wr_global;
        wr_entry.pfn[0] = wr_pfn0;
        wr_entry.pfn[1] = wr_pfn1;
        wr_entry.valid  = wr_valid;
        wr_entry.dirty  = wr_dirty;
    end

    ptlb_entry_bank #(.ENTRIES(ENTRIES)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(wr_entry),
        .lk_addr(lk_addr), .lk_asid(lk_asid), .ent_q(ent_q), .hit_vec(hit_vec)
    );

    ptlb_pick #(.N(ENTRIES)) u_pick (
        .clk(clk), .rst(rst), .hit_vec(hit_vec), .win_idx(win_idx), .win_any(win_any)
    );

    always_comb begin
        win     = ent_q[win_idx];
        em      = eff_mask(win.mask);
        pmask   = em >> 1;
        odd     = |(lk_addr & em & ~pmask);
        c_paddr = '0;
        c_wr    = 1'b0;
        if (!win_any) begin
            c_code = RES_NOMATCH;
        end else if (!win.valid[odd]) begin
            c_code = RES_INVALID;
        end else if (lk_write && !win.dirty[odd]) begin
            c_code = RES_MODIFY;
        end else begin
            c_code  = RES_HIT;
            c_paddr = {win.pfn[odd], {PAGE_SH{1'b0}}} | (lk_addr & pmask);
            c_wr    = win.dirty[odd];
        end
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_code     <= RES_NOMATCH;
                res_paddr    <= '0;
                res_writable <= 1'b0;
            end else begin
                res_code     <= c_code;
                res_paddr    <= c_paddr;
                res_writable <= c_wr;
            end
        end
    end else begin : g_comb
        always_comb begin
            res_code     = c_code;
            res_paddr    = c_paddr;
            res_writable = c_wr;
        end
    end

    ptlb_capture u_cap (
        .clk(clk), .rst(rst), .fault_ld(lk_req && (c_code != RES_HIT)), .va(lk_addr),
        .sw_ctx_we(cap_ctx_we), .sw_ehi_we(cap_ehi_we), .sw_wdata(cap_wdata),
        .ctx_q(cap_ctx), .ehi_q(cap_ehi)
    );

    // R5: a modify result only comes from a write access
    p_modify_is_write_r5: assert property (@(posedge clk) disable iff (rst)
        (c_code == RES_MODIFY) |-> lk_write);
    // R5: a successful write is always to a writable half
    p_write_hit_writable_r5: assert property (@(posedge clk) disable iff (rst)
        ((c_code == RES_HIT) && lk_write) |-> c_wr);
endmodule

// File: tb/pair_tlb_test.sv
`timescale 1ns/1ps
module pair_tlb_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [18:0] wr_vpn = 0, wr_mask = 0;
    logic [7:0]  wr_asid = 0;
    logic        wr_global = 0;
    logic [19:0] wr_pfn0 = 0, wr_pfn1 = 0;
    logic [1:0]  wr_valid = 0, wr_dirty = 0;
    logic        lk_req = 0, lk_write = 0;
    logic [31:0] lk_addr = 0;
    logic [7:0]  lk_asid = 0;
    logic        cap_ctx_we = 0, cap_ehi_we = 0;
    logic [31:0] cap_wdata = 0;
    logic [1:0]  res_code, r_code;
    logic [31:0] res_paddr, r_paddr, cap_ctx, cap_ehi, r_ctx, r_ehi;
    logic        res_writable, r_wr;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pair_tlb #(.ENTRIES(16), .REGISTERED(1'b0)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
        .wr_asid(wr_asid), .wr_global(wr_global), .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
        .wr_valid(wr_valid), .wr_dirty(wr_dirty), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_write(lk_write), .lk_asid(lk_asid), .cap_ctx_we(cap_ctx_we), .cap_ehi_we(cap_ehi_we),
        .cap_wdata(cap_wdata), .res_code(res_code), .res_paddr(res_paddr),
        .res_writable(res_writable), .cap_ctx(cap_ctx), .cap_ehi(cap_ehi));

    pair_tlb #(.ENTRIES(16), .REGISTERED(1'b1)) uut_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
        .wr_asid(wr_asid), .wr_global(wr_global), .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
        .wr_valid(wr_valid), .wr_dirty(wr_dirty), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_write(lk_write), .lk_asid(lk_asid), .cap_ctx_we(cap_ctx_we), .cap_ehi_we(cap_ehi_we),
        .cap_wdata(cap_wdata), .res_code(r_code), .res_paddr(r_paddr),
        .res_writable(r_wr), .cap_ctx(r_ctx), .cap_ehi(r_ehi));

    // bench-side model of the entry table
    logic [18:0] m_vpn [16];
    logic [18:0] m_mask [16];
    logic [7:0]  m_asid [16];
    logic        m_g [16];
    logic [19:0] m_pfn0 [16], m_pfn1 [16];
    logic [1:0]  m_v [16], m_d [16];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] a, input logic w, input logic [7:0] asid,
                         output logic [1:0] code, output logic [31:0] pa, output logic wr);
        code = 2'd1; pa = 0; wr = 0;
        for (int i = 15; i >= 0; i--) begin
            logic [31:0] em;
            em = {m_mask[i], 13'h1FFF};
            if ((m_g[i] || m_asid[i] == asid) && ((a & ~em) == ({m_vpn[i], 13'h0} & ~em))) begin
                logic [31:0] pm;
                int h;
                pm = em >> 1;
                h  = ((a & (em ^ pm)) != 0) ? 1 : 0;
                pa = 0; wr = 0;
                if (!m_v[i][h]) code = 2'd2;
                else if (w && !m_d[i][h]) code = 2'd3;
                else begin
                    code = 2'd0;
                    pa = {(h != 0) ? m_pfn1[i] : m_pfn0[i], 12'h0} | (a & pm);
                    wr = m_d[i][h];
                end
            end
        end
    endtask

    task automatic wr_ent(input int idx, input logic [18:0] vpn, input logic [18:0] msk,
                          input logic [7:0] asid, input logic g, input logic [19:0] p0,
                          input logic [19:0] p1, input logic [1:0] v, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_mask = msk; wr_asid = asid;
        wr_global = g; wr_pfn0 = p0; wr_pfn1 = p1; wr_valid = v; wr_dirty = d;
        m_vpn[idx] = vpn; m_mask[idx] = msk; m_asid[idx] = asid; m_g[idx] = g;
        m_pfn0[idx] = p0; m_pfn1[idx] = p1; m_v[idx] = v; m_d[idx] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(input string tag, input logic [31:0] a, input logic w, input logic [7:0] asid);
        logic [1:0] ec; logic [31:0] ep; logic ew;
        @(negedge clk);
        lk_addr = a; lk_write = w; lk_asid = asid;
        #1;
        model(a, w, asid, ec, ep, ew);
        chk({tag, " code"}, 32'(res_code), 32'(ec));
        chk({tag, " paddr R2/R6"}, res_paddr, ep);
        chk({tag, " writable R5/R6"}, 32'(res_writable), 32'(ew));
    endtask

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'd0: return "R5 hit";
            2'd1: return "R6 nomatch";
            2'd2: return "R4 invalid";
            default: return "R5 modify";
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [6];
        logic [31:0] offs [10];
        for (int i = 0; i < 16; i++) begin
            m_vpn[i] = 0; m_mask[i] = 0; m_asid[i] = 0; m_g[i] = 0;
            m_pfn0[i] = 0; m_pfn1[i] = 0; m_v[i] = 0; m_d[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        // R10: reset state
        chk("R10 ctx reset", cap_ctx, 32'h0);
        chk("R10 ehi reset", cap_ehi, 32'h0);
        look("R10 reset far addr", 32'h0000_4000, 0, 8'd5);
        chk("R10 far addr nomatch", 32'(res_code), 32'd1);
        look("R10 reset zero-tag", 32'h0000_1000, 0, 8'd0);
        chk("R10 reset entry invalid", 32'(res_code), 32'd2);

        // program a table
        wr_ent(0, 19'h00200, 19'h0,  8'd1, 0, 20'h12345, 20'h6789A, 2'b11, 2'b10);
        wr_ent(1, 19'h08000, 19'h3,  8'd9, 1, 20'h00800, 20'h00C00, 2'b01, 2'b01);
        wr_ent(2, 19'h00200, 19'h0,  8'd2, 0, 20'hAAAA0, 20'hBBBB0, 2'b11, 2'b11);
        wr_ent(5, 19'h00200, 19'h0,  8'd1, 0, 20'h55555, 20'h44444, 2'b11, 2'b11);
        wr_ent(6, 19'h20000, 19'hFF, 8'd3, 0, 20'h30000, 20'h31000, 2'b10, 2'b10);
        wr_ent(7, 19'h7FFF0, 19'h0,  8'd0, 1, 20'hFFFFE, 20'hFFFFF, 2'b11, 2'b01);

        // targeted checks
        look("R3 even half", 32'h0040_0ABC, 0, 8'd1);
        chk("R3 even paddr", res_paddr, 32'h1234_5ABC);
        look("R3 odd half", 32'h0040_1ABC, 0, 8'd1);
        chk("R3 odd paddr", res_paddr, 32'h6789_AABC);
        look("R5 clean write", 32'h0040_0010, 1, 8'd1);
        chk("R5 modify code", 32'(res_code), 32'd3);
        look("R5 dirty write", 32'h0040_1010, 1, 8'd1);
        chk("R5 write hit", 32'(res_writable), 32'd1);
        look("R7 lowest wins", 32'h0040_0000, 0, 8'd1);
        chk("R7 entry0 frame", res_paddr, 32'h1234_5000);
        look("R1 asid select", 32'h0040_0000, 0, 8'd2);
        chk("R1 entry2 frame", res_paddr, 32'hAAAA_0000);
        look("R1 asid miss", 32'h0040_0000, 0, 8'd4);
        chk("R1 nomatch", 32'(res_code), 32'd1);
        look("R2 16K even", 32'h1000_3FFC, 0, 8'd77);
        chk("R2 16K paddr", res_paddr, 32'h0080_3FFC);
        look("R4 16K odd invalid write", 32'h1000_4000, 1, 8'd0);
        chk("R4 invalid on write", 32'(res_code), 32'd2);
        look("R4 1M even invalid read", 32'h4000_0000, 0, 8'd3);
        chk("R4 invalid on read", 32'(res_code), 32'd2);
        look("R2 1M odd", 32'h4010_0123, 0, 8'd3);
        chk("R2 1M paddr", res_paddr, 32'h3100_0123);

        // sweep
        bases[0] = 32'h0040_0000; bases[1] = 32'h1000_0000; bases[2] = 32'h4000_0000;
        bases[3] = 32'hFFFE_0000; bases[4] = 32'h0000_0000; bases[5] = 32'h4020_0000;
        offs[0] = 0; offs[1] = 32'hFFC; offs[2] = 32'h1000; offs[3] = 32'h1FFC; offs[4] = 32'h2000;
        offs[5] = 32'h4000; offs[6] = 32'h7FFC; offs[7] = 32'h8000; offs[8] = 32'h10_0000;
        offs[9] = 32'h1F_FFFC;
        for (int b = 0; b < 6; b++)
            for (int o = 0; o < 10; o++)
                for (int s = 0; s < 4; s++)
                    for (int w = 0; w < 2; w++) begin
                        logic [1:0] ec; logic [31:0] ep; logic ew;
                        model(bases[b] + offs[o], w[0], 8'(s), ec, ep, ew);
                        look(tag_of(ec), bases[b] + offs[o], w[0], 8'(s));
                    end

        // R12 software load, R8/R9 fault capture
        @(negedge clk);
        cap_ctx_we = 1; cap_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cap_ctx_we = 0; cap_ehi_we = 1; cap_wdata = 32'h0000_1FAB;
        @(negedge clk);
        cap_ehi_we = 0;
        chk("R12 ctx write", cap_ctx, 32'hFFFF_FFFF);
        chk("R12 ehi write", cap_ehi, 32'h0000_1FAB);
        lk_req = 1; lk_addr = 32'h7654_3210; lk_write = 0; lk_asid = 8'd1;
        @(negedge clk);
        lk_req = 0;
        chk("R8 ctx capture", cap_ctx, (32'hFFFF_FFFF & ~32'h007F_FFF0) | ((32'h7654_3210 >> 13) << 4));
        chk("R9 ehi capture", cap_ehi, 32'h7654_20AB);
        chk("R9 ehi capture registered unit", r_ehi, 32'h7654_20AB);
        lk_req = 1; lk_addr = 32'h0040_1000;
        @(negedge clk);
        lk_req = 0;
        chk("R9 hit leaves ehi", cap_ehi, 32'h7654_20AB);
        chk("R8 hit leaves ctx", cap_ctx, (32'hFFFF_FFFF & ~32'h007F_FFF0) | ((32'h7654_3210 >> 13) << 4));
        lk_req = 1; lk_addr = 32'h0123_4567; cap_ehi_we = 1; cap_wdata = 32'h0000_0042;
        @(negedge clk);
        lk_req = 0; cap_ehi_we = 0;
        chk("R12 software wins", cap_ehi, 32'h0000_0042);

        // R11 registered variant
        @(negedge clk);
        lk_addr = 32'h0040_1ABC; lk_write = 0; lk_asid = 8'd1;
        @(negedge clk);
        lk_addr = 32'h0900_0000;
        #1;
        chk("R11 reg code", 32'(r_code), 32'd0);
        chk("R11 reg paddr held", r_paddr, 32'h6789_AABC);
        chk("R11 comb follows", 32'(res_code), 32'd1);
        @(negedge clk);
        chk("R11 reg updates", 32'(r_code), 32'd1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule